// File: doc/BRIEF.md
# Presence-Vector Coherence Directory

This block sits beside a small on-chip backing store and keeps, for every memory block, one presence bit per processing element and a single dirty bit. Elements send it read, write-ownership and write-back requests over a valid/ready channel. The controller looks up the block's entry and decides whether the request can be answered from memory at once. If it cannot, it sends targeted coherence messages to the elements marked in the presence vector, collects their acknowledgements and any recalled data, updates memory and the entry, and then answers the requester.

Nothing is ever broadcast. Each message goes to exactly one marked element. A dirty entry always names exactly one owner. The controller runs one transaction at a time, so a request to any block, including one whose transaction is still in flight, waits at the request port until the current response has been taken.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every block is clean with no presence bits set, its memory word is 0x5A000000 + 3*block, req_ready is high, and cmd_valid and rsp_valid are low.
- R2: A read (req_op 0) from element i to a clean block sends no message, returns the memory word to i, and sets presence bit i.
- R3: A read from element i to a block dirty in another element sends one downgrade message (cmd_msg 0) to that owner only. The ack_data it returns is written to memory and sent to i. The block becomes clean with both the owner's and i's presence bits set.
- R4: A write request (req_op 1) from element i to a clean block sends one invalidate (cmd_msg 1) to every other marked element and none to i. Once granted, the block is dirty with only presence bit i set, and the response carries the memory word.
- R5: A write request from element i to a block dirty in another element sends one recall-invalidate (cmd_msg 2) to the owner. The returned data is written to memory and sent to i, and ownership moves to i alone.
- R6: A read or write request from the element that already owns a dirty block is answered with the memory word without any message and without changing the entry.
- R7: A write-back (req_op 2) from the dirty owner stores req_wdata, clears the dirty bit and the owner's presence bit, and echoes the stored word. A write-back from any other element leaves memory and the entry unchanged and returns the current word.
- R8: Coherence messages go one per target, only to elements whose presence bit was set when the request was looked up, never to the requester, and in ascending element index.
- R9: Acknowledgements are accepted in any order, including while later messages are still being sent. The response is not offered before every expected acknowledgement has arrived.
- R10: req_ready is low from the cycle after a request is accepted until the cycle after its response handshake.
- R11: A stalled cmd_valid or rsp_valid stays high with its destination unchanged until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken |
| req_src | input | IW | Requesting element |
| req_op | input | 2 | 0 read, 1 write ownership, 2 write-back |
| req_addr | input | AW | Block index |
| req_wdata | input | DW | Write-back data |
| cmd_valid | output | 1 | Coherence message offered |
| cmd_ready | input | 1 | Message taken by network |
| cmd_dst | output | IW | Target element |
| cmd_msg | output | 2 | 0 downgrade, 1 invalidate, 2 recall-invalidate |
| cmd_addr | output | AW | Block index of the message |
| ack_valid | input | 1 | Acknowledgement offered |
| ack_ready | output | 1 | Acknowledgements accepted |
| ack_src | input | IW | Acknowledging element |
| ack_data | input | DW | Recalled line data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_dst | output | IW | Requesting element |
| rsp_data | output | DW | Line data for the requester |

## Verification
The acknowledgement port and the message port can both fire in the same cycle, when the network returns an invalidation acknowledgement while the next invalidation is still being handed out. The bench provokes this by returning each acknowledgement in the cycle right after its message is taken, sometimes while holding cmd_ready low once. It judges the result by comparing the observed message order and targets against its reference model. It also confirms that no response appears while any acknowledgement is still owed. In other transactions the bench returns the acknowledgements only after all messages, in reverse order, so that both orderings are covered.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WBACK = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MSG_DOWNGRADE    = 2'd0,
    MSG_INVAL        = 2'd1,
    MSG_RECALL_INVAL = 2'd2,
    MSG_RSVD         = 2'd3
  } msg_e;

  // Power-on contents of block a: base pattern plus three per block.
  function automatic logic [63:0] blk_seed(input int unsigned a);
    return 64'h5A00_0000 + 64'(a) * 64'd3;
  endfunction

endpackage

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Lowest set index wins.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/dir_array.sv
module dir_array
  import dir_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int NPE  = 4,
  parameter int DW   = 32,
  localparam int AW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr,
  output logic [NPE-1:0]  rd_pres,
  output logic            rd_dirty,
  output logic [DW-1:0]   rd_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NPE-1:0]  wr_pres,
  input  logic            wr_dirty,
  input  logic            wr_data_en,
  input  logic [DW-1:0]   wr_data
);
  logic [NPE-1:0] pres_a  [NBLK];
  logic           dirty_a [NBLK];
  logic [DW-1:0]  data_a  [NBLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        pres_a[b]  <= '0;
        dirty_a[b] <= 1'b0;
        data_a[b]  <= DW'(blk_seed(b));
      end
    end else if (wr_en) begin
      pres_a[wr_addr]  <= wr_pres;
      dirty_a[wr_addr] <= wr_dirty;
      if (wr_data_en) data_a[wr_addr] <= wr_data;
    end
  end

  assign rd_pres  = pres_a[rd_addr];
  assign rd_dirty = dirty_a[rd_addr];
  assign rd_data  = data_a[rd_addr];

  // A dirty entry must name exactly one owner (R4, R5).
  p_dirty_sole_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dirty) |-> ($countones(wr_pres) == 1));
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
  import dir_pkg::*;
#(
  parameter int NPE  = 4,
  parameter int NBLK = 16,
  parameter int DW   = 32,
  localparam int IW  = (NPE > 1) ? $clog2(NPE) : 1,
  localparam int AW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [IW-1:0] req_src,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [IW-1:0] cmd_dst,
  output logic [1:0]    cmd_msg,
  output logic [AW-1:0] cmd_addr,
  input  logic          ack_valid,
  output logic          ack_ready,
  input  logic [IW-1:0] ack_src,
  input  logic [DW-1:0] ack_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [IW-1:0] rsp_dst,
  output logic [DW-1:0] rsp_data
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_SEND, S_WAIT, S_FIN, S_RESP} st_e;

  st_e            state_q;
  logic [IW-1:0]  src_q;
  op_e            op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [NPE-1:0] pres_q, snap_q, tosend_q, wait_q;
  msg_e           msg_q;
  logic [DW-1:0]  data_q;
  logic           fin_dirty_q, fin_wen_q, fin_wb_q;

  // Named events for assertions.
  logic req_fire, cmd_fire, ack_fire, rsp_fire, acks_done;
  logic [NPE-1:0] src_bit, dst_bit, ack_bit;

  logic [NPE-1:0] rd_pres;
  logic           rd_dirty;
  logic [DW-1:0]  rd_data;
  logic           wr_en;
  logic [NPE-1:0] wr_pres;

  logic [IW-1:0]  pick_idx;
  logic           pick_any;

  dir_array #(.NBLK(NBLK), .NPE(NPE), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(addr_q), .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(addr_q), .wr_pres(wr_pres), .wr_dirty(fin_dirty_q),
    .wr_data_en(fin_wen_q), .wr_data(data_q)
  );

  dir_pick #(.N(NPE)) u_pick (.vec(tosend_q), .idx(pick_idx), .any(pick_any));

  assign req_ready = (state_q == S_IDLE);
  assign cmd_valid = (state_q == S_SEND) && pick_any;
  assign cmd_dst   = pick_idx;
  assign cmd_msg   = msg_q;
  assign cmd_addr  = addr_q;
  assign ack_ready = (state_q == S_SEND) || (state_q == S_WAIT);
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_dst   = src_q;
  assign rsp_data  = data_q;

  assign req_fire  = req_valid && req_ready;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign ack_fire  = ack_valid && ack_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign acks_done = (wait_q == '0);
  assign src_bit   = NPE'(1) << src_q;
  assign dst_bit   = NPE'(1) << pick_idx;
  assign ack_bit   = (NPE'(1) << ack_src) & wait_q;

  // Final presence vector written when the transaction closes.
  always_comb begin
    case (op_q)
      OP_READ, OP_WRITE: wr_pres = pres_q | src_bit;
      OP_WBACK:          wr_pres = fin_wb_q ? (pres_q & ~src_bit) : pres_q;
      default:           wr_pres = pres_q;
    endcase
  end
  assign wr_en = (state_q == S_FIN);

  // Lookup decision terms.
  logic           owner_other, owner_self;
  logic [NPE-1:0] wr_targets;
  assign owner_other = rd_dirty && !rd_pres[src_q];
  assign owner_self  = rd_dirty &&  rd_pres[src_q];
  assign wr_targets  = owner_other ? rd_pres : (rd_pres & ~src_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      src_q       <= '0;
      op_q        <= OP_READ;
      addr_q      <= '0;
      wdata_q     <= '0;
      pres_q      <= '0;
      snap_q      <= '0;
      tosend_q    <= '0;
      wait_q      <= '0;
      msg_q       <= MSG_DOWNGRADE;
      data_q      <= '0;
      fin_dirty_q <= 1'b0;
      fin_wen_q   <= 1'b0;
      fin_wb_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_fire) begin
          src_q   <= req_src;
          op_q    <= op_e'(req_op);
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          pres_q   <= rd_pres;
          snap_q   <= rd_pres;
          data_q   <= rd_data;
          fin_wb_q <= 1'b0;
          case (op_q)
            OP_READ: begin
              fin_dirty_q <= owner_self;
              fin_wen_q   <= owner_other;
              msg_q       <= MSG_DOWNGRADE;
              tosend_q    <= owner_other ? rd_pres : '0;
              wait_q      <= owner_other ? rd_pres : '0;
              state_q     <= owner_other ? S_SEND : S_FIN;
            end
            OP_WRITE: begin
              fin_dirty_q <= 1'b1;
              fin_wen_q   <= owner_other;
              msg_q       <= owner_other ? MSG_RECALL_INVAL : MSG_INVAL;
              tosend_q    <= wr_targets;
              wait_q      <= wr_targets;
              state_q     <= (wr_targets != '0) ? S_SEND : S_FIN;
            end
            OP_WBACK: begin
              fin_dirty_q <= owner_self ? 1'b0 : rd_dirty;
              fin_wen_q   <= owner_self;
              fin_wb_q    <= owner_self;
              data_q      <= owner_self ? wdata_q : rd_data;
              tosend_q    <= '0;
              wait_q      <= '0;
              state_q     <= S_FIN;
            end
            default: begin
              fin_dirty_q <= rd_dirty;
              fin_wen_q   <= 1'b0;
              tosend_q    <= '0;
              wait_q      <= '0;
              state_q     <= S_FIN;
            end
          endcase
        end
        S_SEND, S_WAIT: begin
          if (cmd_fire) begin
            tosend_q <= tosend_q & ~dst_bit;
            if ((tosend_q & ~dst_bit) == '0) state_q <= S_WAIT;
          end
          if (ack_fire && (ack_bit != '0)) begin
            wait_q <= wait_q & ~ack_bit;
            if (msg_q != MSG_DOWNGRADE) pres_q <= pres_q & ~ack_bit;
            if (msg_q != MSG_INVAL)     data_q <= ack_data;
          end
          if (state_q == S_WAIT && acks_done) state_q <= S_FIN;
        end
        S_FIN:  state_q <= S_RESP;
        S_RESP: if (rsp_fire) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Messages only reach elements marked at lookup, never the requester.
  p_cmd_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (snap_q[cmd_dst] && (cmd_dst != src_q)));
  // No grant while an acknowledgement is owed.
  p_grant_after_acks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> acks_done);
  // A write leaves no other sharer behind.
  p_write_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FIN && op_q == OP_WRITE) |-> ((pres_q & ~src_bit) == '0));
  // Accepted request blocks the port.
  p_busy_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  // Stalled outputs hold.
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_dst)));
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/test_dir_coherence_ctrl.sv
module test_dir_coherence_ctrl;
  localparam int NPE = 4, NBLK = 16, DW = 32, IW = 2, AW = 4;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, cmd_ready = 0, ack_valid = 0, rsp_ready = 0;
  logic [IW-1:0] req_src = 0, ack_src = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0, ack_data = 0;
  logic req_ready, cmd_valid, ack_ready, rsp_valid;
  logic [IW-1:0] cmd_dst, rsp_dst;
  logic [1:0] cmd_msg;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] rsp_data;

  dir_coherence_ctrl #(.NPE(NPE), .NBLK(NBLK), .DW(DW)) i_dir_coherence_ctrl (.*);

  int nchk = 0, nfail = 0, txn_no = 0;
  bit busy = 0, finished = 0;

  // Reference state
  bit [NPE-1:0] m_pres [NBLK];
  bit           m_dirty[NBLK];
  logic [31:0]  m_mem  [NBLK];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every clock: port readiness against the bench's own busy flag (R10).
  always @(negedge clk) if (rst_n && !finished)
    chk(req_ready == !busy, "R10", "req_ready", req_ready, !busy);

  task automatic run_txn(input int src, input int op, input int addr,
                         input logic [31:0] wd, input bit rev, input bit hold,
                         input string tag);
    int exp_dst[$], exp_msg[$], got_dst[$], got_msg[$], ackq[$];
    int owner = -1;
    bit done = 0, held = 0, rheld = 0;
    int held_dst = 0;
    logic [31:0] rdata, exp_rsp, got_rsp = 0, held_rsp = 0;
    int got_rdst = -1;
    txn_no++;
    rdata = 32'hD000_0000 ^ (addr << 8) ^ (src << 4) ^ txn_no;
    for (int p = 0; p < NPE; p++) if (m_pres[addr][p]) owner = (owner < 0) ? p : owner;
    exp_rsp = m_mem[addr];
    // Expected messages and final state
    if (op == 0) begin
      if (m_dirty[addr] && !m_pres[addr][src]) begin
        exp_dst.push_back(owner); exp_msg.push_back(0);
        exp_rsp = rdata; m_mem[addr] = rdata; m_dirty[addr] = 0;
      end
      m_pres[addr][src] = 1;
    end else if (op == 1) begin
      if (m_dirty[addr] && !m_pres[addr][src]) begin
        exp_dst.push_back(owner); exp_msg.push_back(2);
        exp_rsp = rdata; m_mem[addr] = rdata;
      end else if (!m_dirty[addr]) begin
        for (int p = 0; p < NPE; p++)
          if (m_pres[addr][p] && p != src) begin exp_dst.push_back(p); exp_msg.push_back(1); end
      end
      m_pres[addr] = '0; m_pres[addr][src] = 1; m_dirty[addr] = 1;
    end else begin
      if (m_dirty[addr] && m_pres[addr][src]) begin
        m_mem[addr] = wd; m_dirty[addr] = 0; m_pres[addr][src] = 0; exp_rsp = wd;
      end
    end
    // Issue request
    @(negedge clk);
    chk(req_ready, tag, "ready before request", req_ready, 1);
    req_valid = 1; req_src = IW'(src); req_op = 2'(op); req_addr = AW'(addr); req_wdata = wd;
    @(posedge clk); busy = 1;
    for (int cyc = 0; cyc < 80 && !done; cyc++) begin
      bit ctake, rtake;
      @(negedge clk);
      req_valid = 0; ack_valid = 0;
      if (held) begin
        chk(cmd_valid && cmd_dst == IW'(held_dst), "R11", "held command", cmd_dst, held_dst);
        held = 0;
      end
      if (hold && !held && cmd_valid && got_dst.size() == 0 && cyc < 40 && held_dst != -2) begin
        cmd_ready = 0; held = 1; held_dst = cmd_dst;
      end else cmd_ready = 1;
      if (!held && held_dst >= 0 && got_dst.size() > 0) held_dst = -2;
      ctake = cmd_valid && cmd_ready;
      if (ack_ready && ackq.size() > 0 && (!rev || got_dst.size() == exp_dst.size())) begin
        int a;
        a = rev ? ackq.pop_back() : ackq.pop_front();
        ack_valid = 1; ack_src = IW'(a);
        ack_data = (exp_msg.size() > 0 && exp_msg[0] != 1) ? rdata : 32'h0;
      end
      if (rsp_valid)
        chk(ackq.size() == 0 && got_dst.size() == exp_dst.size() && !ack_valid, "R9",
            "response before acks", ackq.size(), 0);
      if (rheld) begin
        chk(rsp_valid && rsp_data == held_rsp, "R11", "held response", rsp_data, held_rsp);
        rsp_ready = 1;
      end else if (hold && rsp_valid) begin
        rsp_ready = 0; rheld = 1; held_rsp = rsp_data;
      end else rsp_ready = 1;
      rtake = rsp_valid && rsp_ready;
      if (ctake) begin
        chk(cmd_addr == AW'(addr), "R8", "command address", cmd_addr, addr);
        got_dst.push_back(cmd_dst); got_msg.push_back(cmd_msg); ackq.push_back(cmd_dst);
      end
      if (rtake) begin got_rsp = rsp_data; got_rdst = rsp_dst; end
      @(posedge clk);
      if (rtake) begin busy = 0; done = 1; end
    end
    @(negedge clk); ack_valid = 0; rsp_ready = 0; cmd_ready = 0;
    chk(done, tag, "transaction completed", done, 1);
    chk(got_dst.size() == exp_dst.size(), "R8", "message count", got_dst.size(), exp_dst.size());
    for (int k = 0; k < exp_dst.size() && k < got_dst.size(); k++) begin
      chk(got_dst[k] == exp_dst[k], "R8", "message target/order", got_dst[k], exp_dst[k]);
      chk(got_msg[k] == exp_msg[k], tag, "message kind", got_msg[k], exp_msg[k]);
    end
    chk(got_rdst == src, tag, "response destination", got_rdst, src);
    chk(got_rsp == exp_rsp, tag, "response data", got_rsp, exp_rsp);
  endtask

  initial begin
    int unsigned r = 32'h1234_5678;
    for (int b = 0; b < NBLK; b++) begin
      m_pres[b] = '0; m_dirty[b] = 0; m_mem[b] = 32'h5A00_0000 + b * 3;
    end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !rsp_valid, "R1", "idle outputs after reset",
        {req_ready, cmd_valid, rsp_valid}, 3'b100);
    run_txn(0, 0, 3, 0, 0, 0, "R1");          // seed word
    run_txn(2, 0, 3, 0, 0, 0, "R2");
    run_txn(1, 0, 3, 0, 0, 0, "R2");
    run_txn(1, 1, 3, 0, 1, 0, "R4");          // invalidate 0 and 2, reversed acks
    run_txn(1, 1, 3, 0, 0, 0, "R6");
    run_txn(1, 0, 3, 0, 0, 0, "R6");
    run_txn(3, 0, 3, 0, 0, 0, "R3");          // downgrade owner 1
    run_txn(0, 0, 3, 0, 0, 0, "R3");          // memory holds recalled word
    run_txn(0, 1, 3, 0, 0, 1, "R4");          // overlapping acks, stalled port
    run_txn(2, 1, 3, 0, 0, 0, "R5");
    run_txn(1, 2, 3, 32'hBAD0_0001, 0, 0, "R7"); // non-owner write-back ignored
    run_txn(3, 0, 3, 0, 0, 0, "R7");          // still owned by 2
    run_txn(3, 1, 5, 0, 0, 0, "R4");
    run_txn(3, 2, 5, 32'hC0FF_EE05, 0, 0, "R7");
    run_txn(0, 0, 5, 0, 0, 0, "R7");
    run_txn(0, 1, 5, 0, 0, 0, "R7");          // element 3 no longer marked
    for (int n = 0; n < 60; n++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      run_txn(int'(r[17:16]), int'(r[21:20]) % 3, int'(r[25:24]), r, r[28], r[29], "R8");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1;
    nfail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule